// File: doc/BRIEF.md
# Oscillator Sub-Band Calibration Sequencer

This block selects one of 32 capacitor sub-bands for an on-chip oscillator before the phase-locked loop is closed. With the loop filter parked at mid-rail, it steps a 5-bit band code through a successive-approximation search. In each step it watches one comparison window, which runs from one reference-divider strobe to the next, and notes whether the feedback-divider strobe arrived first. When the search ends, the code stays on the capacitor bank and the loop takes over fine tuning.

A register interface supplies a start bit and an init bit. A calibration begins only on a 0-to-1 change of the start bit. While the sweep runs the charge pump is held off. Completion is flagged by an active-low done output. The init bit returns the sequencer to idle at any time. If the reference strobes stop, a programmable timeout ends the sweep with an error flag, so the sequencer never stalls waiting for a strobe.

Top module: `vco_band_cal`

## Requirements
- R1: After reset, the outputs are: cal_done_n = 1, cp_inhibit = 0, cal_error = 0, band_code = 5'b10000 (mid band).
- R2: A calibration is accepted only on a cycle where start_bit is 1 after being 0 on the previous cycle, while the block is idle or done and init_bit is 0. A start_bit held at 1 never starts a second calibration, and a new rising edge during a running calibration is ignored.
- R3: From the cycle after an accepted start until the calibration finishes, cp_inhibit = 1, cal_done_n = 1 and cal_error = 0.
- R4: The first trial code is 5'b10000. The search resolves bits MSB first. A bit is cleared when a fb_tick arrives strictly before the ref_tick that closes its window. It is kept when the fb_tick comes later, in the same cycle as that ref_tick, or not at all. The next lower bit is then set for the following window.
- R5: The final band_code is the largest code whose feedback edge does not precede the reference edge within a window.
- R6: A complete calibration consumes exactly 7 ref_tick strobes while cp_inhibit is 1: one settle window, five search windows and one final settle window. cal_done_n falls in the cycle after the seventh.
- R7: When done, cal_done_n = 0 and cp_inhibit = 0. band_code then stays constant until the next accepted start, init or reset.
- R8: init_bit = 1 returns the block within one cycle to the R1 output values and holds it there. A start_bit that is already 1 when init_bit returns to 0 does not start a calibration.
- R9: While running, if tmo_limit consecutive cycles pass with no ref_tick, the block ends with cal_error = 1, cal_done_n = 0, cp_inhibit = 0 and band_code = 5'b10000. cal_error clears on the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_bit | input | 1 | Register bit; rising edge requests a calibration |
| init_bit | input | 1 | Register bit; while 1 the sequencer is forced to idle |
| ref_tick | input | 1 | Single-cycle strobe from the reference divider, synchronised |
| fb_tick | input | 1 | Single-cycle strobe from the feedback divider, synchronised |
| tmo_limit | input | TMO_W | Cycles without a ref_tick before a running sweep is abandoned |
| cp_inhibit | output | 1 | Holds the charge pump off while calibration runs |
| cal_done_n | output | 1 | Active-low end-of-calibration flag |
| band_code | output | BAND_W | Band code driving the capacitor bank; readable as status |
| cal_error | output | 1 | Set when a sweep ended by timeout |

## Verification
The hardest case to reach from the ports is a tie, where the feedback edge lands in the same cycle as the closing reference edge. The other hard cases are codes at the ends of the range, where every window or no window sees the feedback edge first. The bench places a behavioural oscillator in the loop. The oscillator's period shrinks by one cycle per band-code step, and its feedback strobe is timed from each reference strobe. Choosing the reference period therefore fixes which window ties and which code is correct. Aborts are reached by silencing the reference model and by raising init_bit mid-sweep.

// File: rtl/bandcal_pkg.sv
package bandcal_pkg;

    typedef enum logic [2:0] {
        CS_IDLE,
        CS_PRE,
        CS_MEAS,
        CS_POST,
        CS_DONE
    } cal_state_e;

    function automatic logic is_running(cal_state_e s);
        return (s == CS_PRE) || (s == CS_MEAS) || (s == CS_POST);
    endfunction

    function automatic logic can_accept(cal_state_e s);
        return (s == CS_IDLE) || (s == CS_DONE);
    endfunction

endpackage

// File: rtl/bandcal_edge.sv
module bandcal_edge (
    input  logic clk,
    input  logic start_bit,
    output logic start_rise
);
    logic start_prev;

    // tracks the bit even in reset so a level held through reset is not an edge
    always_ff @(posedge clk) begin
        start_prev <= start_bit;
    end

    assign start_rise = start_bit & ~start_prev;
endmodule

// File: rtl/bandcal_race.sv
module bandcal_race (
    input  logic clk,
    input  logic rst,
    input  logic ref_tick,
    input  logic fb_tick,
    output logic fb_first
);
    // a feedback edge coincident with the closing reference edge is a tie: not first
    always_ff @(posedge clk) begin
        if (rst || ref_tick) begin
            fb_first <= 1'b0;
        end else if (fb_tick) begin
            fb_first <= 1'b1;
        end
    end
endmodule

// File: rtl/bandcal_sar.sv
module bandcal_sar #(
    parameter int BAND_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic              too_fast,
    output logic [BAND_W-1:0] trial,
    output logic              last
);
    localparam logic [BAND_W-1:0] MID = {1'b1, {(BAND_W-1){1'b0}}};

    logic [BAND_W-1:0] mask;
    logic [BAND_W-1:0] kept;

    // per-bit decision: only the bit under test may be dropped
    for (genvar b = 0; b < BAND_W; b++) begin : g_bit
        assign kept[b] = trial[b] & ~(mask[b] & too_fast);
    end

    always_ff @(posedge clk) begin
        if (rst || load) begin
            trial <= MID;
            mask  <= MID;
        end else if (step) begin
            trial <= kept | (mask >> 1);
            mask  <= mask >> 1;
        end
    end

    assign last = mask[0];
endmodule

// File: rtl/bandcal_timer.sv
module bandcal_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             ref_tick,
    input  logic [TMO_W-1:0] limit,
    output logic             expire
);
    logic [TMO_W-1:0] gap_cnt;

    assign expire = run && !ref_tick && (gap_cnt == limit - TMO_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run || ref_tick) begin
            gap_cnt <= '0;
        end else begin
            gap_cnt <= gap_cnt + TMO_W'(1);
        end
    end
endmodule

// File: rtl/vco_band_cal.sv
module vco_band_cal
    import bandcal_pkg::*;
#(
    parameter int BAND_W     = 5,
    parameter int TMO_W      = 16,
    parameter int PRE_TICKS  = 1,   // settle windows before the search, at least 1
    parameter int POST_TICKS = 1    // settle windows after the search, at least 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_bit,
    input  logic              init_bit,
    input  logic              ref_tick,
    input  logic              fb_tick,
    input  logic [TMO_W-1:0]  tmo_limit,
    output logic              cp_inhibit,
    output logic              cal_done_n,
    output logic [BAND_W-1:0] band_code,
    output logic              cal_error
);
    localparam int PH_MAX = (PRE_TICKS > POST_TICKS) ? PRE_TICKS : POST_TICKS;
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam logic [PH_W-1:0] PRE_LAST  = PH_W'(PRE_TICKS - 1);
    localparam logic [PH_W-1:0] POST_LAST = PH_W'(POST_TICKS - 1);

    cal_state_e        state;
    logic [PH_W-1:0]   ph_cnt;
    logic              err_q;
    logic              start_rise;
    logic              start_go;
    logic              fb_first;
    logic              expire;
    logic              sar_load;
    logic              sar_step;
    logic              sar_last;
    logic [BAND_W-1:0] trial;

    bandcal_edge u_edge (
        .clk        (clk),
        .start_bit  (start_bit),
        .start_rise (start_rise)
    );

    bandcal_race u_race (
        .clk      (clk),
        .rst      (rst),
        .ref_tick (ref_tick),
        .fb_tick  (fb_tick),
        .fb_first (fb_first)
    );

    bandcal_timer #(.TMO_W(TMO_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (is_running(state)),
        .ref_tick (ref_tick),
        .limit    (tmo_limit),
        .expire   (expire)
    );

    assign start_go = start_rise && can_accept(state) && !init_bit;
    assign sar_load = init_bit || start_go || expire;
    assign sar_step = (state == CS_MEAS) && ref_tick && !init_bit;

    bandcal_sar #(.BAND_W(BAND_W)) u_sar (
        .clk      (clk),
        .rst      (rst),
        .load     (sar_load),
        .step     (sar_step),
        .too_fast (fb_first),
        .trial    (trial),
        .last     (sar_last)
    );

    always_ff @(posedge clk) begin
        if (rst || init_bit) begin
            state  <= CS_IDLE;
            ph_cnt <= '0;
            err_q  <= 1'b0;
        end else begin
            unique case (state)
                CS_IDLE, CS_DONE: begin
                    if (start_go) begin
                        state  <= CS_PRE;
                        ph_cnt <= '0;
                        err_q  <= 1'b0;
                    end
                end
                CS_PRE: begin
                    if (expire) begin
                        state <= CS_DONE;
                        err_q <= 1'b1;
                    end else if (ref_tick) begin
                        if (ph_cnt == PRE_LAST) begin
                            state  <= CS_MEAS;
                            ph_cnt <= '0;
                        end else begin
                            ph_cnt <= ph_cnt + PH_W'(1);
                        end
                    end
                end
                CS_MEAS: begin
                    if (expire) begin
                        state <= CS_DONE;
                        err_q <= 1'b1;
                    end else if (ref_tick && sar_last) begin
                        state  <= CS_POST;
                        ph_cnt <= '0;
                    end
                end
                CS_POST: begin
                    if (expire) begin
                        state <= CS_DONE;
                        err_q <= 1'b1;
                    end else if (ref_tick) begin
                        if (ph_cnt == POST_LAST) begin
                            state <= CS_DONE;
                        end else begin
                            ph_cnt <= ph_cnt + PH_W'(1);
                        end
                    end
                end
                default: state <= CS_IDLE;
            endcase
        end
    end

    assign cp_inhibit = is_running(state);
    assign cal_done_n = (state != CS_DONE);
    assign band_code  = trial;
    assign cal_error  = err_q;
endmodule

// File: rtl/bandcal_chk.sv
module bandcal_chk #(
    parameter int BAND_W = 5,
    parameter int TMO_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start_bit,
    input logic              init_bit,
    input logic              ref_tick,
    input logic [TMO_W-1:0]  tmo_limit,
    input logic              cp_inhibit,
    input logic              cal_done_n,
    input logic [BAND_W-1:0] band_code,
    input logic              cal_error
);
    localparam logic [BAND_W-1:0] MID = {1'b1, {(BAND_W-1){1'b0}}};

    logic [TMO_W:0] quiet_cnt;

    always_ff @(posedge clk) begin
        if (rst || !cp_inhibit || ref_tick) begin
            quiet_cnt <= '0;
        end else begin
            quiet_cnt <= quiet_cnt + (TMO_W+1)'(1);
        end
    end

    AST_INHIBIT_NOT_DONE: assert property (@(posedge clk) disable iff (rst)
        cp_inhibit |-> cal_done_n);  // R3

    AST_START_ACCEPTED: assert property (@(posedge clk) disable iff (rst)
        ($rose(start_bit) && !init_bit && !cp_inhibit) |=> (cp_inhibit && cal_done_n && !cal_error));  // R2

    AST_FIRST_TRIAL_MID: assert property (@(posedge clk) disable iff (rst)
        $rose(cp_inhibit) |-> (band_code == MID));  // R4

    AST_DONE_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
        (!cal_done_n && $past(!cal_done_n)) |-> $stable(band_code));  // R7

    AST_INIT_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        init_bit |=> (cal_done_n && !cp_inhibit && !cal_error && band_code == MID));  // R8

    AST_ERROR_MEANS_DONE: assert property (@(posedge clk) disable iff (rst)
        cal_error |-> (!cal_done_n && !cp_inhibit));  // R9

    AST_QUIET_BOUND: assert property (@(posedge clk) disable iff (rst)
        (tmo_limit != '0) |-> (quiet_cnt <= {1'b0, tmo_limit}));  // R9
endmodule

bind vco_band_cal bandcal_chk #(.BAND_W(BAND_W), .TMO_W(TMO_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .start_bit  (start_bit),
    .init_bit   (init_bit),
    .ref_tick   (ref_tick),
    .tmo_limit  (tmo_limit),
    .cp_inhibit (cp_inhibit),
    .cal_done_n (cal_done_n),
    .band_code  (band_code),
    .cal_error  (cal_error)
);

// File: tb/vco_band_cal_tb_top.sv
module vco_band_cal_tb_top;
    localparam int PBASE = 70;   // oscillator period in cycles at code 0; one cycle shorter per step
    localparam int NVEC  = 10;
    // {reference period, expected code = clamp(PBASE - period, 0, 31)}
    localparam int VEC [NVEC][2] = '{
        '{55, 15}, '{70, 0}, '{71, 0}, '{39, 31}, '{30, 31},
        '{40, 30}, '{60, 10}, '{48, 22}, '{63, 7},  '{54, 16}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        start_bit;
    logic        init_bit;
    logic        ref_tick;
    logic        fb_tick;
    logic [15:0] tmo_limit;
    logic        cp_inhibit;
    logic        cal_done_n;
    logic [4:0]  band_code;
    logic        cal_error;

    int  n_chk = 0;
    int  n_bad = 0;
    int  ref_per = 55;
    bit  ref_en = 1'b0;
    int  rcnt = 0;
    bit  mon_clr = 1'b0;
    int  run_ticks = 0;
    int  inh_cyc = 0;
    bit  seen_inh = 1'b0;

    always #4 clk = ~clk;

    vco_band_cal dut_i (
        .clk        (clk),
        .rst        (rst),
        .start_bit  (start_bit),
        .init_bit   (init_bit),
        .ref_tick   (ref_tick),
        .fb_tick    (fb_tick),
        .tmo_limit  (tmo_limit),
        .cp_inhibit (cp_inhibit),
        .cal_done_n (cal_done_n),
        .band_code  (band_code),
        .cal_error  (cal_error)
    );

    // behavioural oscillator and dividers: feedback edge timed from each reference edge
    always @(negedge clk) begin
        if (!ref_en) begin
            ref_tick = 1'b0;
            fb_tick  = 1'b0;
            rcnt     = 0;
        end else begin
            ref_tick = (rcnt >= ref_per - 1);
            fb_tick  = (rcnt == PBASE - int'(band_code) - 1) && !ref_tick;
            rcnt     = ref_tick ? 0 : rcnt + 1;
        end
    end

    always @(posedge clk) begin
        if (mon_clr) begin
            run_ticks <= 0;
            inh_cyc   <= 0;
            seen_inh  <= 1'b0;
        end else begin
            if (ref_tick && cp_inhibit) run_ticks <= run_ticks + 1;
            if (cp_inhibit) begin
                inh_cyc  <= inh_cyc + 1;
                seen_inh <= 1'b1;
            end
        end
    end

    task automatic check_eq(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(negedge clk) mon_clr = 1'b1;
        @(negedge clk) mon_clr = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk) start_bit = 1'b0;
        @(negedge clk) start_bit = 1'b1;
    endtask

    task automatic wait_done(int lim);
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (!cal_done_n) break;
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; start_bit = 1'b0; init_bit = 1'b0; tmo_limit = 16'd1000;
        ref_en = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1", "done_n after reset", int'(cal_done_n), 1);
        check_eq("R1", "inhibit after reset", int'(cp_inhibit), 0);
        check_eq("R1", "error after reset", int'(cal_error), 0);
        check_eq("R1", "code after reset", int'(band_code), 16);

        // R5 R6 R7: vector table walk
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk) start_bit = 1'b0;
            ref_per = VEC[v][0];
            repeat (3) @(negedge clk);
            clear_mon();
            pulse_start();
            wait_done(2000);
            check_eq("R5", $sformatf("code for period %0d", VEC[v][0]), int'(band_code), VEC[v][1]);
            check_eq("R6", "reference strobes used", run_ticks, 7);
            check_eq("R7", "inhibit at done", int'(cp_inhibit), 0);
            check_eq("R7", "done_n at done", int'(cal_done_n), 0);
        end

        // R2 R7: held start level must not retrigger; code held
        clear_mon();
        repeat (300) @(negedge clk);
        check_eq("R2", "held start retrigger", int'(seen_inh), 0);
        check_eq("R7", "code held while done", int'(band_code), 16);
        check_eq("R7", "still done", int'(cal_done_n), 0);

        // R2: rising edge during a run is ignored
        @(negedge clk) start_bit = 1'b0;
        ref_per = 60;
        repeat (3) @(negedge clk);
        clear_mon();
        pulse_start();
        for (int i = 0; i < 1000 && run_ticks < 2; i++) @(negedge clk);
        start_bit = 1'b0;
        @(negedge clk) start_bit = 1'b1;
        wait_done(2000);
        check_eq("R2", "code after mid-run edge", int'(band_code), 10);
        check_eq("R2", "strobes after mid-run edge", run_ticks, 7);

        // R8: init aborts, then held start does not launch on release
        clear_mon();
        pulse_start();
        for (int i = 0; i < 1000 && run_ticks < 3; i++) @(negedge clk);
        check_eq("R3", "inhibit mid-run", int'(cp_inhibit), 1);
        check_eq("R3", "done_n mid-run", int'(cal_done_n), 1);
        init_bit = 1'b1;
        @(negedge clk);
        check_eq("R8", "done_n after init", int'(cal_done_n), 1);
        check_eq("R8", "inhibit after init", int'(cp_inhibit), 0);
        check_eq("R8", "code after init", int'(band_code), 16);
        repeat (5) @(negedge clk);
        init_bit = 1'b0;
        clear_mon();
        repeat (200) @(negedge clk);
        check_eq("R8", "launch after init release", int'(seen_inh), 0);

        // R9: silent reference ends the run with an error
        @(negedge clk) start_bit = 1'b0;
        ref_en = 1'b0;
        tmo_limit = 16'd20;
        repeat (4) @(negedge clk);
        clear_mon();
        pulse_start();
        wait_done(500);
        check_eq("R9", "inhibit cycles before timeout", inh_cyc, 20);
        check_eq("R9", "error flag", int'(cal_error), 1);
        check_eq("R9", "code after timeout", int'(band_code), 16);
        check_eq("R9", "done_n after timeout", int'(cal_done_n), 0);

        // R9 R3: next start clears the error
        tmo_limit = 16'd1000;
        ref_en = 1'b1;
        ref_per = 48;
        repeat (4) @(negedge clk);
        clear_mon();
        pulse_start();
        @(negedge clk);
        check_eq("R3", "inhibit after start", int'(cp_inhibit), 1);
        check_eq("R3", "done_n after start", int'(cal_done_n), 1);
        check_eq("R9", "error cleared on start", int'(cal_error), 0);
        wait_done(2000);
        check_eq("R4", "code after recovery", int'(band_code), 22);

        finish_run();
    end
endmodule